// File: doc/BRIEF.md
# Interrupt and Reset Vector Arbiter

This block collects every reason a small microcontroller core might leave its instruction stream. These reasons are three reset causes, three nonmaskable requests and a set of maskable peripheral requests. From them it presents one registered request with the vector code of the highest-priority winner. Maskable peripheral requests are qualified by a global mask bit and by a per-source local enable. Some of them share a vector slot, and software tells those apart later by reading peripheral flags.

A small priority register can raise any one maskable vector slot above all other maskable slots. The core may change that register only while it has maskable interrupts masked, and any other write is dropped. Once the arbiter presents a result, the result stays frozen until the core pulses acknowledge. Arbitration runs again on the clock after that.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While and after reset, `req_o` is 0 and the priority register selects slot 0, so the maskable order matches the fixed order.
- R2: Reset causes beat everything else. `rst_cause_i[0]` (power-on/external, code 0) ranks above `rst_cause_i[1]` (clock monitor, code 1), which ranks above `rst_cause_i[2]` (watchdog, code 2).
- R3: Nonmaskable requests rank below resets and above all maskable requests, in the order illegal opcode (code 3), software interrupt (code 4), then the X pin (code 5). The X pin is blocked while `x_mask_i` is 1. The first two ignore both mask bits.
- R4: No maskable source is recognized while `i_mask_i` is 1.
- R5: A maskable source needs its `irq_en_i` bit set, except source 0 (the external IRQ pin), whose enable bit is ignored.
- R6: Maskable source s maps to slot s when s < 15, and to slot 29-s otherwise. So sources 15..18 share slots 14..11. Any qualified source on a slot asserts it, and slot k is reported as code 6+k.
- R7: Among pending maskable slots, the lowest slot number wins unless R8 applies.
- R8: When the slot held in the priority register is pending, it wins over every other maskable slot.
- R9: A priority write (`prio_we_i`) takes effect only while `i_mask_i` is 1 and `prio_wdata_i` < 15. Any other write leaves the order unchanged.
- R10: The result is registered. It appears on the clock after the inputs, and while `req_o` is 1 without `ack_i`, both `req_o` and `vec_o` hold regardless of input changes.
- R11: An acknowledge clock clears `req_o`. The next clock arbitrates afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_cause_i | input | 3 | Reset causes: [0] power-on, [1] clock monitor, [2] watchdog |
| illop_i | input | 1 | Illegal-opcode trap request |
| swi_i | input | 1 | Software interrupt request |
| xirq_i | input | 1 | X pin interrupt request |
| x_mask_i | input | 1 | Blocks the X pin request when 1 |
| i_mask_i | input | 1 | Global maskable-interrupt mask |
| irq_req_i | input | 19 | Maskable source request lines |
| irq_en_i | input | 19 | Per-source local enables (bit 0 ignored) |
| prio_we_i | input | 1 | Priority register write strobe |
| prio_wdata_i | input | 4 | Slot to promote |
| ack_i | input | 1 | Core acknowledge of the presented vector |
| req_o | output | 1 | A vector is being presented |
| vec_o | output | 5 | Vector code of the winner |

## Verification
Every arbitration result is due one clock after its inputs are applied. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It also checks that nothing is visible before that edge. A priority write is due at the edge where it is strobed, so its effect is probed with a request applied in the following cycle. After an acknowledge, `req_o` is checked low one edge later and the fresh winner one edge after that.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned CODE_POR   = 0;
  localparam int unsigned CODE_CMF   = 1;
  localparam int unsigned CODE_COP   = 2;
  localparam int unsigned CODE_ILLOP = 3;
  localparam int unsigned CODE_SWI   = 4;
  localparam int unsigned CODE_XIRQ  = 5;
  localparam int unsigned CODE_MBASE = 6;

  // sources beyond the slot count fold back onto the top slots
  function automatic int unsigned slot_of(int unsigned src, int unsigned n_vec);
    return (src < n_vec) ? src : (2 * n_vec - 1 - src);
  endfunction
endpackage

// File: rtl/irq_src_qualify.sv
module irq_src_qualify #(
  parameter int unsigned N_MSRC = 19,
  parameter int unsigned N_MVEC = 15
) (
  input  logic [N_MSRC-1:0] req_i,
  input  logic [N_MSRC-1:0] en_i,
  input  logic              i_mask_i,
  output logic [N_MVEC-1:0] slot_pend_o
);
  import irq_arb_pkg::*;

  logic [N_MSRC-1:0] eff_en;
  logic [N_MSRC-1:0] src_ok;

  // source 0 is the bare IRQ pin: no local enable
  assign eff_en = en_i | {{(N_MSRC-1){1'b0}}, 1'b1};
  assign src_ok = req_i & eff_en & {N_MSRC{~i_mask_i}};

  for (genvar v = 0; v < N_MVEC; v++) begin : g_slot
    always_comb begin
      slot_pend_o[v] = 1'b0;
      for (int unsigned s = 0; s < N_MSRC; s++)
        if (slot_of(s, N_MVEC) == v && src_ok[s]) slot_pend_o[v] = 1'b1;
    end
  end

  always_comb begin
    if (i_mask_i) a_r4_masked_quiet : assert (slot_pend_o == '0);
  end
endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg #(
  parameter int unsigned N_MVEC = 15,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] wdata_i,
  input  logic              i_mask_i,
  output logic [SLOT_W-1:0] prio_o
);
  logic wr_ok;

  assign wr_ok = we_i && i_mask_i && (32'(wdata_i) < N_MVEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prio_o <= '0;
    else if (wr_ok) prio_o <= wdata_i;
  end

  a_r9_locked_unmasked : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !i_mask_i |=> $stable(prio_o));
  a_r9_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(prio_o) < N_MVEC);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_MVEC = 15,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned VEC_W  = 5
) (
  input  logic [2:0]        rst_cause_i,
  input  logic              illop_i,
  input  logic              swi_i,
  input  logic              xirq_i,
  input  logic              x_mask_i,
  input  logic [N_MVEC-1:0] slot_pend_i,
  input  logic [SLOT_W-1:0] prio_i,
  output logic              any_o,
  output logic [VEC_W-1:0]  code_o
);
  import irq_arb_pkg::*;

  logic              promo_hit;
  logic [SLOT_W-1:0] fixed_win;
  logic [SLOT_W-1:0] m_win;

  always_comb begin
    promo_hit = 1'b0;
    for (int unsigned v = 0; v < N_MVEC; v++)
      if (SLOT_W'(v) == prio_i && slot_pend_i[v]) promo_hit = 1'b1;
  end

  // descending scan: lowest pending slot is written last
  always_comb begin
    fixed_win = '0;
    for (int v = N_MVEC - 1; v >= 0; v--)
      if (slot_pend_i[v]) fixed_win = SLOT_W'(v);
  end

  assign m_win = promo_hit ? prio_i : fixed_win;

  always_comb begin
    any_o  = 1'b1;
    code_o = '0;
    if (rst_cause_i[0])            code_o = VEC_W'(CODE_POR);
    else if (rst_cause_i[1])       code_o = VEC_W'(CODE_CMF);
    else if (rst_cause_i[2])       code_o = VEC_W'(CODE_COP);
    else if (illop_i)              code_o = VEC_W'(CODE_ILLOP);
    else if (swi_i)                code_o = VEC_W'(CODE_SWI);
    else if (xirq_i && !x_mask_i)  code_o = VEC_W'(CODE_XIRQ);
    else if (|slot_pend_i)         code_o = VEC_W'(CODE_MBASE) + VEC_W'(m_win);
    else                           any_o  = 1'b0;
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int unsigned N_MSRC = 19,
  parameter int unsigned N_MVEC = 15,
  localparam int unsigned SLOT_W = $clog2(N_MVEC),
  localparam int unsigned N_CODE = irq_arb_pkg::CODE_MBASE + N_MVEC,
  localparam int unsigned VEC_W  = $clog2(N_CODE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        rst_cause_i,
  input  logic              illop_i,
  input  logic              swi_i,
  input  logic              xirq_i,
  input  logic              x_mask_i,
  input  logic              i_mask_i,
  input  logic [N_MSRC-1:0] irq_req_i,
  input  logic [N_MSRC-1:0] irq_en_i,
  input  logic              prio_we_i,
  input  logic [SLOT_W-1:0] prio_wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_MVEC-1:0] slot_pend;
  logic [SLOT_W-1:0] prio;
  logic              any;
  logic [VEC_W-1:0]  code;
  logic              req_q;
  logic [VEC_W-1:0]  vec_q;

  irq_src_qualify #(.N_MSRC(N_MSRC), .N_MVEC(N_MVEC)) u_qual (
    .req_i(irq_req_i), .en_i(irq_en_i), .i_mask_i(i_mask_i), .slot_pend_o(slot_pend)
  );

  irq_prio_reg #(.N_MVEC(N_MVEC), .SLOT_W(SLOT_W)) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(prio_we_i), .wdata_i(prio_wdata_i),
    .i_mask_i(i_mask_i), .prio_o(prio)
  );

  irq_pick #(.N_MVEC(N_MVEC), .SLOT_W(SLOT_W), .VEC_W(VEC_W)) u_pick (
    .rst_cause_i(rst_cause_i), .illop_i(illop_i), .swi_i(swi_i), .xirq_i(xirq_i),
    .x_mask_i(x_mask_i), .slot_pend_i(slot_pend), .prio_i(prio),
    .any_o(any), .code_o(code)
  );

  // hold until ack; ack cycle drops req, next cycle re-arbitrates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else begin
      req_q <= any;
      vec_q <= code;
    end
  end

  assign req_o = req_q;
  assign vec_o = vec_q;

  a_r10_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q && $stable(vec_q));
  a_r11_ack_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && ack_i |=> !req_q);
  a_r2_por_first : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && rst_cause_i[0] |=> req_q && vec_q == '0);
  a_r4_mask_blocks : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q && i_mask_i && rst_cause_i == 3'b000 && !illop_i && !swi_i
      && !(xirq_i && !x_mask_i) |=> !req_q);
  a_r6_code_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> 32'(vec_q) < N_CODE);
endmodule

// File: tb/irq_vector_arbiter_test.sv
`timescale 1ns/1ps
module irq_vector_arbiter_test;
  localparam logic [18:0] ALL = 19'h7FFFF;

  typedef struct packed {
    logic [2:0]  rst;
    logic        ill;
    logic        swi;
    logic        xirq;
    logic        im;
    logic        xm;
    logic [18:0] req;
    logic [18:0] en;
    logic        ereq;
    logic [4:0]  evec;
    logic [7:0]  rtag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ALL,       ALL,       1'b1, 5'd0,  8'd2}, // R2
    '{3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0,     19'h0,     1'b1, 5'd1,  8'd2}, // R2
    '{3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0,     19'h0,     1'b1, 5'd2,  8'd2}, // R2
    '{3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, ALL,       ALL,       1'b1, 5'd3,  8'd3}, // R3
    '{3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 19'h0,     19'h0,     1'b1, 5'd4,  8'd3}, // R3
    '{3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 19'h0,     19'h0,     1'b1, 5'd5,  8'd3}, // R3
    '{3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h8,     19'h8,     1'b1, 5'd9,  8'd3}, // R3
    '{3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 19'h0,     19'h0,     1'b1, 5'd4,  8'd3}, // R3
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 19'h4,     19'h4,     1'b0, 5'd0,  8'd4}, // R4
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h4,     19'h0,     1'b0, 5'd0,  8'd5}, // R5
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h1,     19'h0,     1'b1, 5'd6,  8'd5}, // R5
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h220,   ALL,       1'b1, 5'd11, 8'd7}, // R7
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h8000,  19'h8000,  1'b1, 5'd20, 8'd6}, // R6
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h40000, 19'h40000, 1'b1, 5'd17, 8'd6}, // R6
    '{3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h12000, 19'h10000, 1'b1, 5'd19, 8'd6}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rst_c;
  logic        ill, swi, xirq, xmask, imask, we, ack;
  logic [18:0] req, en;
  logic [3:0]  wd;
  logic        req_o;
  logic [4:0]  vec_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_vector_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .rst_cause_i(rst_c), .illop_i(ill), .swi_i(swi),
    .xirq_i(xirq), .x_mask_i(xmask), .i_mask_i(imask), .irq_req_i(req),
    .irq_en_i(en), .prio_we_i(we), .prio_wdata_i(wd), .ack_i(ack),
    .req_o(req_o), .vec_o(vec_o)
  );

  task automatic idle();
    rst_c = '0; ill = 0; swi = 0; xirq = 0; xmask = 0; imask = 0;
    req = '0; en = '0; we = 0; wd = '0; ack = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic ereq, logic [4:0] evec);
    checks++;
    if (req_o !== ereq || (ereq && vec_o !== evec)) begin
      fails++;
      $display("FAIL %s: req=%0b vec=%0d expected req=%0b vec=%0d",
               tag, req_o, vec_o, ereq, evec);
    end
  endtask

  task automatic retire();
    idle(); ack = 1; step(); ack = 0; step();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) step();
    check("R1 in reset", 1'b0, 5'd0);
    rst_n = 1;
    step();
    check("R1 after reset", 1'b0, 5'd0);

    for (int i = 0; i < NV; i++) begin
      rst_c = TBL[i].rst; ill = TBL[i].ill; swi = TBL[i].swi; xirq = TBL[i].xirq;
      imask = TBL[i].im; xmask = TBL[i].xm; req = TBL[i].req; en = TBL[i].en;
      step();
      check($sformatf("R%0d table row %0d", TBL[i].rtag, i), TBL[i].ereq, TBL[i].evec);
      retire();
    end

    // R8: promote slot 7 while masked
    imask = 1; we = 1; wd = 4'd7; step();
    idle(); req = 19'h84; en = 19'h84; step();
    check("R8 promoted slot 7", 1'b1, 5'd13);
    retire();
    req = 19'h14; en = 19'h14; step();
    check("R8 others keep fixed order", 1'b1, 5'd8);
    retire();

    // R9: write while unmasked is dropped
    we = 1; wd = 4'd4; step();
    idle(); req = 19'h14; en = 19'h14; step();
    check("R9 unmasked write ignored", 1'b1, 5'd8);
    retire();
    // R9: out-of-range slot dropped
    imask = 1; we = 1; wd = 4'd15; step();
    idle(); req = 19'h84; en = 19'h84; step();
    check("R9 out-of-range write ignored", 1'b1, 5'd13);
    retire();

    // R10 latency and hold, R11 ack sequence
    req = 19'h8; en = 19'h8;
    check("R10 not visible before edge", 1'b0, 5'd0);
    step();
    check("R10 due one clock later", 1'b1, 5'd9);
    rst_c = 3'b001; step(); step();
    check("R10 held without ack", 1'b1, 5'd9);
    ack = 1; step(); ack = 0;
    check("R11 cleared by ack", 1'b0, 5'd0);
    step();
    check("R11 fresh arbitration", 1'b1, 5'd0);
    retire();

    summary();
  end
endmodule